// File: doc/BRIEF.md
# Asynchronous static memory bus controller

This block accepts single read and write requests from the chip's internal side and turns each into one timed access on a shared external bus. SRAM, PSRAM and NOR devices sit on that bus. Up to four devices share the address, data and strobe lines, and each device has its own active-low chip select. Only one external access runs at a time. The internal side uses a valid/ready handshake to present an address, write data, byte enables, a write flag and a chip-select index. Read data and write completion come back as a one-cycle response pulse.

Each chip select has its own 48-bit configuration word. The word holds 4-bit cycle counts for the read phases and a separate set for the write phases. It also holds a byte-lane lead time, a multiplexed address/data enable, the data width (8 or 16 bits), the wait polarity and an asynchronous wait enable. A phase with a zero count is skipped. Data setup always lasts at least one cycle. An external wait input, synchronised by two flops, can stretch the data setup phase.

The sequencer has seven states. IDLE goes to the first non-empty phase when a request is accepted. The phases run in the order LEAD (byte lanes ahead of chip select), ASET (address setup, address strobe low), AHLD (address hold, multiplexed mode only), DSET (data setup, strobe low), DHLD (data hold) and TURN (bus turnaround). Each phase ends when its count runs out and moves to the next non-empty phase, or back to IDLE. DSET does not end while a wait is enabled and active.

Top module: `async_mem_ctrl`

## Requirements
- R1: After reset, every chip select, `mem_noe_o`, `mem_nwe_o`, `mem_nadv_o` and both `mem_nbl_o` bits are high, `mem_dq_oe_o` is low, `req_ready_o` is high and `rsp_valid_o` is low.
- R2: A request is accepted only while `req_ready_o` is high. `req_ready_o` is high only when no access is in progress and no chip select is low. At most one chip select is ever low, namely bit `req_cs_i` of `mem_ncs_o`.
- R3: An access runs LEAD, ASET, AHLD, DSET, DHLD, TURN in that order. Each phase lasts exactly its 4-bit count in clock cycles, and a zero count skips the phase. A DSET count of 0 acts as 1. The chip select is low from the start of ASET to the end of DHLD. In TURN, chip select and byte lanes are high and `req_ready_o` stays low.
- R4: For a read, `mem_noe_o` is low in exactly the DSET cycles. `mem_dq_i` is captured on the last DSET cycle. In the next cycle `rsp_valid_o` is high for exactly one cycle, with the captured value on `rsp_rdata_o`.
- R5: A write uses the write count set, not the read set. `mem_nwe_o` is low in exactly the DSET cycles, and `rsp_valid_o` pulses once in the cycle after DSET. In non-multiplexed mode, `mem_dq_oe_o` is high with `mem_dq_o` equal to the write data from the start of ASET to the end of DHLD. In a non-multiplexed read, `mem_dq_oe_o` stays low.
- R6: During LEAD, `mem_nbl_o` equals the inverted, width-masked byte enables while every chip select is high. LEAD lasts the lead count. `mem_nbl_o` keeps that value until DHLD ends.
- R7: `mem_nadv_o` is low in exactly the ASET cycles.
- R8: The AHLD phase exists only when the multiplexed mode bit is set. In that mode `mem_dq_oe_o` is high with `mem_dq_o` equal to address bits [15:0] throughout ASET and AHLD, for both reads and writes. `mem_dq_oe_o` is never high while `mem_noe_o` is low.
- R9: With the width bit clear (8-bit), `mem_nbl_o[1]` stays high and `rsp_rdata_o[15:8]` is zero. With it set (16-bit), both lanes follow the byte enables and all 16 data bits are captured.
- R10: With the wait enable set, the wait is active when the synchronised `mem_wait_i` equals the polarity bit (0 means active low). While the wait is active, DSET holds. If the wait is active from before DSET and goes inactive during DSET cycle c, DSET lasts c + 1 + count cycles.
- R11: With the wait enable clear, `mem_wait_i` has no effect, and DSET lasts exactly its count.
- R12: `cfg_i[48*k +: 48]` configures chip select k, with fields from the MSB down as follows. Five read counts: address setup, address hold, data setup, data hold, turnaround. The same five counts for writes. The lead count (4 bits each). Then the multiplexed bit, the width bit (1 = 16-bit), the wait polarity bit and the wait enable bit. The word is sampled when the request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller idle, request taken this cycle |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_cs_i | input | 2 | Target chip select index |
| req_addr_i | input | 24 | Device address |
| req_wdata_i | input | 16 | Write data |
| req_be_i | input | 2 | Byte enables, bit 0 = low byte |
| rsp_valid_o | output | 1 | One-cycle completion pulse |
| rsp_rdata_o | output | 16 | Captured read data |
| cfg_i | input | 192 | Four 48-bit per-chip-select configuration words |
| mem_ncs_o | output | 4 | Active-low chip selects |
| mem_noe_o | output | 1 | Active-low output enable |
| mem_nwe_o | output | 1 | Active-low write enable |
| mem_nbl_o | output | 2 | Active-low byte lane enables |
| mem_nadv_o | output | 1 | Active-low address valid |
| mem_addr_o | output | 24 | Address bus |
| mem_dq_o | output | 16 | Data bus out |
| mem_dq_oe_o | output | 1 | Data bus drive enable |
| mem_dq_i | input | 16 | Data bus in |
| mem_wait_i | input | 1 | Asynchronous wait from the device |

## Verification
The assertions assume `req_cs_i` is always below four, since an index out of range would drive no chip select. The response-pulse property also relies on the fact that an accepted request needs at least two cycles before its data setup can end. The stimulus only issues requests with a valid index and non-zero byte enables. It moves the wait input only at falling clock edges, at least three cycles before the access it should affect or during a known DSET cycle, so the synchroniser delay is fixed. Each configuration word is rewritten only while the controller is idle.

// File: rtl/amc_pkg.sv
package amc_pkg;

    localparam int TW     = 4;
    localparam int NUM_PH = 7;

    typedef logic [TW-1:0] tcnt_t;

    typedef struct packed {
        tcnt_t rd_aset;
        tcnt_t rd_ahld;
        tcnt_t rd_dset;
        tcnt_t rd_dhld;
        tcnt_t rd_turn;
        tcnt_t wr_aset;
        tcnt_t wr_ahld;
        tcnt_t wr_dset;
        tcnt_t wr_dhld;
        tcnt_t wr_turn;
        tcnt_t lead;
        logic  mux_en;
        logic  wide;
        logic  wait_hi;
        logic  wait_en;
    } cs_cfg_t;

    localparam int CFG_W = $bits(cs_cfg_t);

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_LEAD = 3'd1,
        ST_ASET = 3'd2,
        ST_AHLD = 3'd3,
        ST_DSET = 3'd4,
        ST_DHLD = 3'd5,
        ST_TURN = 3'd6
    } phase_t;

endpackage

// File: rtl/amc_cfg_sel.sv
module amc_cfg_sel
    import amc_pkg::*;
#(
    parameter int NUM_CS = 4,
    localparam int SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic [NUM_CS*CFG_W-1:0] cfg_flat_i,
    input  logic [SEL_W-1:0]        sel_i,
    output cs_cfg_t                 cfg_o
);

    cs_cfg_t bank [NUM_CS];

    for (genvar k = 0; k < NUM_CS; k++) begin : g_unpack
        assign bank[k] = cs_cfg_t'(cfg_flat_i[k*CFG_W +: CFG_W]);
    end

    assign cfg_o = bank[sel_i];

endmodule

// File: rtl/amc_wait_sync.sv
module amc_wait_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/amc_seq.sv
module amc_seq
    import amc_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int AW     = 24,
    parameter int DW     = 16,
    localparam int SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
    localparam int LANES = DW / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid_i,
    output logic             req_ready_o,
    input  logic             req_wr_i,
    input  logic [SEL_W-1:0] req_cs_i,
    input  logic [AW-1:0]    req_addr_i,
    input  logic [DW-1:0]    req_wdata_i,
    input  logic [LANES-1:0] req_be_i,
    input  cs_cfg_t          sel_cfg_i,
    input  logic             wait_lvl_i,
    output logic             rsp_valid_o,
    output logic [DW-1:0]    rsp_rdata_o,
    output logic [NUM_CS-1:0] mem_ncs_o,
    output logic             mem_noe_o,
    output logic             mem_nwe_o,
    output logic [LANES-1:0] mem_nbl_o,
    output logic             mem_nadv_o,
    output logic [AW-1:0]    mem_addr_o,
    output logic [DW-1:0]    mem_dq_o,
    output logic             mem_dq_oe_o,
    input  logic [DW-1:0]    mem_dq_i
);

    phase_t     st_q, st_d, nxt;
    tcnt_t      cnt_q, cnt_d;
    tcnt_t      dur [NUM_PH];

    cs_cfg_t    cfg_q, cur_cfg;
    logic       wr_q, cur_wr;
    logic [SEL_W-1:0] cs_q;
    logic [AW-1:0]    addr_q;
    logic [DW-1:0]    wdata_q;
    logic [LANES-1:0] be_q;
    logic [DW-1:0]    rdata_q;
    logic             rsp_q;

    logic accept, stall, leave, dset_done;
    logic [LANES-1:0] lane_mask;
    logic [DW-1:0]    data_mask;
    logic [NUM_CS-1:0] cs_low;
    logic [LANES-1:0] bl_low;

    // Configuration in force: the selected word while idle, the latched word otherwise.
    always_comb begin
        cur_cfg = (st_q == ST_IDLE) ? sel_cfg_i : cfg_q;
        cur_wr  = (st_q == ST_IDLE) ? req_wr_i  : wr_q;
    end

    // Duration of every phase for the access in force.
    always_comb begin
        dur[ST_IDLE] = '0;
        dur[ST_LEAD] = cur_cfg.lead;
        dur[ST_ASET] = cur_wr ? cur_cfg.wr_aset : cur_cfg.rd_aset;
        dur[ST_AHLD] = !cur_cfg.mux_en ? '0 :
                       (cur_wr ? cur_cfg.wr_ahld : cur_cfg.rd_ahld);
        dur[ST_DSET] = cur_wr ? cur_cfg.wr_dset : cur_cfg.rd_dset;
        if (dur[ST_DSET] == '0) begin
            dur[ST_DSET] = TW'(1);
        end
        dur[ST_DHLD] = cur_wr ? cur_cfg.wr_dhld : cur_cfg.rd_dhld;
        dur[ST_TURN] = cur_wr ? cur_cfg.wr_turn : cur_cfg.rd_turn;
    end

    // First non-empty phase after the current one; IDLE when none remains.
    always_comb begin
        nxt = ST_IDLE;
        for (int i = NUM_PH - 1; i > 0; i--) begin
            if (i > int'(st_q) && dur[i] != '0) begin
                nxt = phase_t'(3'(i));
            end
        end
    end

    assign accept    = req_valid_i && (st_q == ST_IDLE);
    assign stall     = (st_q == ST_DSET) && cfg_q.wait_en &&
                       (wait_lvl_i == cfg_q.wait_hi);
    assign leave     = (st_q != ST_IDLE) && !stall && (cnt_q <= TW'(1));
    assign dset_done = (st_q == ST_DSET) && leave;

    // Next state and phase counter.
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_IDLE: begin
                if (accept) begin
                    st_d  = nxt;
                    cnt_d = dur[nxt];
                end
            end
            ST_DSET: begin
                if (leave) begin
                    st_d  = nxt;
                    cnt_d = dur[nxt];
                end else if (!stall) begin
                    cnt_d = cnt_q - TW'(1);
                end
            end
            ST_LEAD, ST_ASET, ST_AHLD, ST_DHLD, ST_TURN: begin
                if (leave) begin
                    st_d  = nxt;
                    cnt_d = dur[nxt];
                end else begin
                    cnt_d = cnt_q - TW'(1);
                end
            end
            default: begin
                st_d  = ST_IDLE;
                cnt_d = '0;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign lane_mask = cfg_q.wide ? '1 : LANES'(1);
    assign data_mask = cfg_q.wide ? '1 : DW'(8'hFF);

    // Request latch, read capture and response pulse.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            wr_q    <= 1'b0;
            cs_q    <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
            rdata_q <= '0;
            rsp_q   <= 1'b0;
        end else begin
            if (accept) begin
                cfg_q   <= sel_cfg_i;
                wr_q    <= req_wr_i;
                cs_q    <= req_cs_i;
                addr_q  <= req_addr_i;
                wdata_q <= req_wdata_i;
                be_q    <= req_be_i;
            end
            rsp_q <= dset_done;
            if (dset_done && !wr_q) begin
                rdata_q <= mem_dq_i & data_mask;
            end
        end
    end

    assign cs_low = NUM_CS'(1) << cs_q;
    assign bl_low = be_q & lane_mask;

    // Output decode.
    always_comb begin
        mem_ncs_o   = '1;
        mem_nbl_o   = '1;
        mem_nadv_o  = 1'b1;
        mem_noe_o   = 1'b1;
        mem_nwe_o   = 1'b1;
        mem_dq_o    = '0;
        mem_dq_oe_o = 1'b0;
        unique case (st_q)
            ST_IDLE, ST_TURN: begin
            end
            ST_LEAD: begin
                mem_nbl_o = ~bl_low;
            end
            ST_ASET, ST_AHLD: begin
                mem_ncs_o  = ~cs_low;
                mem_nbl_o  = ~bl_low;
                mem_nadv_o = (st_q != ST_ASET);
                if (cfg_q.mux_en) begin
                    mem_dq_o    = addr_q[DW-1:0];
                    mem_dq_oe_o = 1'b1;
                end else if (wr_q) begin
                    mem_dq_o    = wdata_q;
                    mem_dq_oe_o = 1'b1;
                end
            end
            ST_DSET, ST_DHLD: begin
                mem_ncs_o = ~cs_low;
                mem_nbl_o = ~bl_low;
                if (st_q == ST_DSET) begin
                    mem_noe_o = wr_q;
                    mem_nwe_o = !wr_q;
                end
                if (wr_q) begin
                    mem_dq_o    = wdata_q;
                    mem_dq_oe_o = 1'b1;
                end
            end
            default: begin
            end
        endcase
    end

    assign req_ready_o = (st_q == ST_IDLE);
    assign rsp_valid_o = rsp_q;
    assign rsp_rdata_o = rdata_q;
    assign mem_addr_o  = addr_q;

    // Assertions.
    AST_ONE_CS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mem_ncs_o)); // R2

    AST_READY_BUS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready_o |-> (&mem_ncs_o && mem_noe_o && mem_nwe_o)); // R2

    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |=> !rsp_valid_o); // R4

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_noe_o && !mem_nwe_o)); // R5

    AST_ADV_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_nadv_o |-> !(&mem_ncs_o)); // R7

    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_noe_o |-> !mem_dq_oe_o); // R8

    AST_WAIT_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_noe_o && stall) |=> !mem_noe_o); // R10

endmodule

// File: rtl/async_mem_ctrl.sv
module async_mem_ctrl
    import amc_pkg::*;
#(
    parameter int NUM_CS      = 4,
    parameter int AW          = 24,
    parameter int DW          = 16,
    parameter int SYNC_STAGES = 2,
    localparam int SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
    localparam int LANES = DW / 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid_i,
    output logic                    req_ready_o,
    input  logic                    req_wr_i,
    input  logic [SEL_W-1:0]        req_cs_i,
    input  logic [AW-1:0]           req_addr_i,
    input  logic [DW-1:0]           req_wdata_i,
    input  logic [LANES-1:0]        req_be_i,
    output logic                    rsp_valid_o,
    output logic [DW-1:0]           rsp_rdata_o,
    input  logic [NUM_CS*CFG_W-1:0] cfg_i,
    output logic [NUM_CS-1:0]       mem_ncs_o,
    output logic                    mem_noe_o,
    output logic                    mem_nwe_o,
    output logic [LANES-1:0]        mem_nbl_o,
    output logic                    mem_nadv_o,
    output logic [AW-1:0]           mem_addr_o,
    output logic [DW-1:0]           mem_dq_o,
    output logic                    mem_dq_oe_o,
    input  logic [DW-1:0]           mem_dq_i,
    input  logic                    mem_wait_i
);

    cs_cfg_t sel_cfg;
    logic    wait_lvl;

    amc_cfg_sel #(
        .NUM_CS (NUM_CS)
    ) u_cfg_sel (
        .cfg_flat_i (cfg_i),
        .sel_i      (req_cs_i),
        .cfg_o      (sel_cfg)
    );

    amc_wait_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_wait_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (mem_wait_i),
        .sync_o  (wait_lvl)
    );

    amc_seq #(
        .NUM_CS (NUM_CS),
        .AW     (AW),
        .DW     (DW)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid_i),
        .req_ready_o (req_ready_o),
        .req_wr_i    (req_wr_i),
        .req_cs_i    (req_cs_i),
        .req_addr_i  (req_addr_i),
        .req_wdata_i (req_wdata_i),
        .req_be_i    (req_be_i),
        .sel_cfg_i   (sel_cfg),
        .wait_lvl_i  (wait_lvl),
        .rsp_valid_o (rsp_valid_o),
        .rsp_rdata_o (rsp_rdata_o),
        .mem_ncs_o   (mem_ncs_o),
        .mem_noe_o   (mem_noe_o),
        .mem_nwe_o   (mem_nwe_o),
        .mem_nbl_o   (mem_nbl_o),
        .mem_nadv_o  (mem_nadv_o),
        .mem_addr_o  (mem_addr_o),
        .mem_dq_o    (mem_dq_o),
        .mem_dq_oe_o (mem_dq_oe_o),
        .mem_dq_i    (mem_dq_i)
    );

endmodule

// File: tb/sim_async_mem_ctrl.sv
module sim_async_mem_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NV         = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_wr = 1'b0;
    logic [1:0]  req_cs = '0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [191:0] cfg = '0;
    logic [3:0]  ncs;
    logic        noe, nwe, nadv, dq_oe;
    logic [1:0]  nbl;
    logic [23:0] maddr;
    logic [15:0] dq_o;
    logic [15:0] dq_i = '0;
    logic        wait_i = 1'b1;

    int checks = 0;
    int errors = 0;

    int n_bls, n_cs, n_adv, n_oe, n_we, n_turn, n_dqoe, n_adq, n_badcs, n_badbl, n_rsp;
    logic [15:0] rsp_d;

    typedef struct packed {
        logic [1:0] cs;
        logic       wr;
        logic [3:0] aset;
        logic [3:0] ahld;
        logic [3:0] dset;
        logic [3:0] dhld;
        logic [3:0] turn;
        logic [3:0] bls;
        logic       mux;
        logic       wide;
        logic [1:0] be;
        logic [4:0] exp_cs;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 4'd2, 4'd3, 4'd3, 4'd1, 4'd2, 4'd1, 1'b0, 1'b1, 2'd3, 5'd6},
        '{2'd1, 1'b1, 4'd1, 4'd0, 4'd0, 4'd2, 4'd0, 4'd0, 1'b0, 1'b1, 2'd2, 5'd4},
        '{2'd2, 1'b0, 4'd0, 4'd2, 4'd1, 4'd0, 4'd3, 4'd2, 1'b1, 1'b1, 2'd1, 5'd3},
        '{2'd3, 1'b1, 4'd2, 4'd1, 4'd2, 4'd1, 4'd1, 4'd0, 1'b1, 1'b1, 2'd3, 5'd6},
        '{2'd0, 1'b0, 4'd1, 4'd0, 4'd4, 4'd0, 4'd0, 4'd3, 1'b0, 1'b0, 2'd3, 5'd5},
        '{2'd1, 1'b1, 4'd0, 4'd5, 4'd2, 4'd0, 4'd1, 4'd0, 1'b0, 1'b0, 2'd3, 5'd2}
    };

    async_mem_ctrl u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid),
        .req_ready_o (req_ready),
        .req_wr_i    (req_wr),
        .req_cs_i    (req_cs),
        .req_addr_i  (req_addr),
        .req_wdata_i (req_wdata),
        .req_be_i    (req_be),
        .rsp_valid_o (rsp_valid),
        .rsp_rdata_o (rsp_rdata),
        .cfg_i       (cfg),
        .mem_ncs_o   (ncs),
        .mem_noe_o   (noe),
        .mem_nwe_o   (nwe),
        .mem_nbl_o   (nbl),
        .mem_nadv_o  (nadv),
        .mem_addr_o  (maddr),
        .mem_dq_o    (dq_o),
        .mem_dq_oe_o (dq_oe),
        .mem_dq_i    (dq_i),
        .mem_wait_i  (wait_i)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", what, act, act, exp, exp);
        end
    endtask

    // Field order from the MSB down, as in R12.
    function automatic logic [47:0] mk_cfg(
        input logic [3:0] ra, rh, rd, rdh, rt,
        input logic [3:0] wa, wh, wd, wdh, wt, bl,
        input logic mux, wide, whi, wen);
        return {ra, rh, rd, rdh, rt, wa, wh, wd, wdh, wt, bl, mux, wide, whi, wen};
    endfunction

    task automatic run_access(input logic [1:0] cs, input logic wr, input logic [23:0] addr,
                              input logic [15:0] wd, input logic [1:0] be,
                              input logic [1:0] exp_bl, input int rel_at, input logic rel_val);
        n_bls = 0; n_cs = 0; n_adv = 0; n_oe = 0; n_we = 0; n_turn = 0;
        n_dqoe = 0; n_adq = 0; n_badcs = 0; n_badbl = 0; n_rsp = 0; rsp_d = '0;
        chk("R2 ready before request", int'(req_ready), 1);
        req_valid = 1'b1; req_wr = wr; req_cs = cs; req_addr = addr;
        req_wdata = wd; req_be = be;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 400; k++) begin
            if (!req_ready) begin
                if (ncs == 4'hF && nbl != 2'b11) n_bls++;
                if (ncs == 4'hF && nbl == 2'b11) n_turn++;
                if (ncs != 4'hF) begin
                    n_cs++;
                    if (ncs != ~(4'b0001 << cs)) n_badcs++;
                    if (nbl != exp_bl) n_badbl++;
                end
                if (!nadv) n_adv++;
                if (!noe) n_oe++;
                if (!nwe) n_we++;
                if (dq_oe) n_dqoe++;
                if (dq_oe && dq_o == addr[15:0]) n_adq++;
                if (!noe && rel_at != 0 && n_oe == rel_at) wait_i = rel_val;
            end
            if (rsp_valid) begin
                n_rsp++;
                rsp_d = rsp_rdata;
            end
            if (req_ready) break;
            @(negedge clk);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle levels after reset.
        chk("R1 reset strobes {ncs,noe,nwe,nadv,nbl}",
            int'({ncs, noe, nwe, nadv, nbl}), int'(9'h1FF));
        chk("R1 reset dq_oe/ready/rsp", int'({dq_oe, req_ready, rsp_valid}), int'(3'b010));

        // Table walk: R2 R3 R4 R5 R6 R7 R8 R9 R12.
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            int dse, ahl, exp_dqoe, exp_adq;
            logic [1:0] mask, ebl;
            logic [15:0] pat, wd;
            logic [23:0] ad;
            logic [47:0] w;
            v    = VECS[i];
            dse  = (v.dset == 0) ? 1 : int'(v.dset);
            ahl  = v.mux ? int'(v.ahld) : 0;
            mask = v.wide ? 2'b11 : 2'b01;
            ebl  = ~(v.be & mask);
            pat  = 16'hA5C3 ^ 16'(i * 16'h1111);
            wd   = 16'hBEE0 + 16'(i);
            ad   = 24'h5A0040 + 24'(i * 24'h0123);
            if (v.wr)
                w = mk_cfg(4'd3, 4'd3, 4'd3, 4'd3, 4'd3,
                           v.aset, v.ahld, v.dset, v.dhld, v.turn, v.bls, v.mux, v.wide, 1'b0, 1'b0);
            else
                w = mk_cfg(v.aset, v.ahld, v.dset, v.dhld, v.turn,
                           4'd3, 4'd3, 4'd3, 4'd3, 4'd3, v.bls, v.mux, v.wide, 1'b0, 1'b0);
            cfg = {4{mk_cfg(4'd7, 4'd7, 4'd7, 4'd7, 4'd7, 4'd7, 4'd7, 4'd7, 4'd7, 4'd7,
                            4'd7, 1'b0, 1'b1, 1'b0, 1'b0)}};
            cfg[48*int'(v.cs) +: 48] = w;
            dq_i = pat;
            run_access(v.cs, v.wr, ad, wd, v.be, ebl, 0, 1'b0);
            exp_adq  = v.mux ? int'(v.aset) + ahl : 0;
            exp_dqoe = v.mux ? exp_adq + (v.wr ? dse + int'(v.dhld) : 0)
                             : (v.wr ? int'(v.exp_cs) : 0);
            chk($sformatf("R3 vec%0d chip-select low cycles", i), n_cs, int'(v.exp_cs));
            chk($sformatf("R3 vec%0d turnaround cycles", i), n_turn, int'(v.turn));
            chk($sformatf("R6 vec%0d byte-lane lead cycles", i), n_bls, int'(v.bls));
            chk($sformatf("R6 R9 vec%0d byte-lane mismatches", i), n_badbl, 0);
            chk($sformatf("R7 vec%0d address-valid cycles", i), n_adv, int'(v.aset));
            chk($sformatf("R4 vec%0d output-enable cycles", i), n_oe, v.wr ? 0 : dse);
            chk($sformatf("R5 vec%0d write-enable cycles", i), n_we, v.wr ? dse : 0);
            chk($sformatf("R5 R8 vec%0d data-drive cycles", i), n_dqoe, exp_dqoe);
            chk($sformatf("R8 vec%0d address-on-data cycles", i), n_adq, exp_adq);
            chk($sformatf("R2 R12 vec%0d wrong chip select cycles", i), n_badcs, 0);
            chk($sformatf("R4 vec%0d response pulses", i), n_rsp, 1);
            chk($sformatf("R2 vec%0d address bus", i), int'(maddr), int'(ad));
            if (!v.wr)
                chk($sformatf("R4 R9 vec%0d read data", i), int'(rsp_d),
                    int'(v.wide ? pat : {8'h00, pat[7:0]}));
        end

        // R10: active-low wait, released during DSET cycle 3; DSET = 3 + 1 + 2.
        cfg[47:0] = mk_cfg(4'd1, 4'd0, 4'd2, 4'd1, 4'd1, 4'd3, 4'd3, 4'd3, 4'd3, 4'd3,
                           4'd0, 1'b0, 1'b1, 1'b0, 1'b1);
        wait_i = 1'b0;
        repeat (3) @(negedge clk);
        run_access(2'd0, 1'b0, 24'h000100, 16'h0000, 2'b11, 2'b00, 3, 1'b1);
        chk("R10 low-active wait stretches data setup", n_oe, 6);
        chk("R10 chip-select low with wait", n_cs, 8);
        chk("R10 response after stretched read", n_rsp, 1);

        // R10: active-high wait, released during DSET cycle 2; DSET = 2 + 1 + 2.
        cfg[47:0] = mk_cfg(4'd1, 4'd0, 4'd2, 4'd1, 4'd1, 4'd3, 4'd3, 4'd3, 4'd3, 4'd3,
                           4'd0, 1'b0, 1'b1, 1'b1, 1'b1);
        wait_i = 1'b1;
        repeat (3) @(negedge clk);
        run_access(2'd0, 1'b0, 24'h000200, 16'h0000, 2'b11, 2'b00, 2, 1'b0);
        chk("R10 high-active wait stretches data setup", n_oe, 5);

        // R11: wait disabled, level held active-low throughout; DSET = 2.
        cfg[47:0] = mk_cfg(4'd1, 4'd0, 4'd2, 4'd1, 4'd1, 4'd3, 4'd3, 4'd3, 4'd3, 4'd3,
                           4'd0, 1'b0, 1'b1, 1'b0, 1'b0);
        wait_i = 1'b0;
        repeat (3) @(negedge clk);
        run_access(2'd0, 1'b0, 24'h000300, 16'h0000, 2'b11, 2'b00, 0, 1'b0);
        chk("R11 disabled wait leaves data setup unchanged", n_oe, 2);
        chk("R11 disabled wait chip-select cycles", n_cs, 4);
        wait_i = 1'b1;

        @(negedge clk);
        chk("R1 R2 bus idle after last access", int'({ncs, noe, nwe, req_ready}), int'(7'h7F));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule